// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block sits between a two-wire serial bus (clock and open-drain data) and the storage side of a byte-addressed nonvolatile memory with a 15-bit word address. It oversamples both bus lines with the system clock, cleans them with a synchronizer and a short agreement filter, and recognises Start and Stop conditions. After a Start it takes a control byte, compares it with a fixed device code and three strap inputs, and then either collects a two-byte word address and write data or serves read data.

Write data leaves the block as one strobe per byte together with the target address, followed by a commit pulse when the master closes the write with Stop. The storage side then runs its write cycle and raises `busy`. While `busy` is high the block acknowledges nothing, so a master can find the end of the write cycle by repeatedly sending a control byte until it is acknowledged. Read data is taken from a combinational read port addressed by the internal pointer. Current-address, random and sequential reads are supported, and sequential reads wrap around the whole array.

When the block transmits, every change of its data drive is held back by a set number of system clocks after the falling clock edge, so that its own output never looks like a bus condition.

Top module: `i2c_mem_slave`

## Requirements
- R1: The first byte after a Start is a control byte. Bits 7..4 must equal 1010, bits 3..1 must equal `strap[2:0]`, and bit 0 selects read (1) or write (0). When code and strap match, the block pulls SDA low during the ninth clock.
- R2: A control byte with a wrong code or wrong strap bits gets no acknowledge. Every later byte up to the next Start is also ignored: no acknowledge, no write strobe and no drive of SDA.
- R3: In a write, the high address byte follows the control byte and the low address byte follows it. Bit 7 of the high byte is ignored. Each byte after that is acknowledged and appears as a one-cycle `wr_strobe` with `wr_addr` and `wr_data`.
- R4: Within a write, the address advances by one per data byte in its low 6 bits only, so it wraps inside a 64-byte page (for example 0x723F is followed by 0x7200).
- R5: A Stop that ends a write with at least one data byte gives one `wr_commit` pulse. A Start in its place, or a Stop with no data byte, gives none.
- R6: A repeated Start after the two address bytes, followed by a read control byte, returns the byte at the loaded address, MSB first.
- R7: In a read, a master acknowledge makes the block send the byte at the next address. The pointer wraps from 0x7FFF to 0x0000.
- R8: After a master non-acknowledge the block releases SDA and drives nothing until the next Start.
- R9: A current-address read (a read control byte without address bytes) returns the byte one past the last byte read or written.
- R10: While `busy` is high, no byte is acknowledged, a correctly addressed control byte included, and the transfer is ignored until the next Start.
- R11: `sda_oe` changes only while SCL is low, and not before `HOLD_CYC` system clocks after the SCL falling edge.
- R12: After reset, `sda_oe`, `wr_strobe` and `wr_commit` are 0.
- R13: A Start or Stop in any state ends the current transfer: a Start waits for a new control byte, and a Stop makes the block idle and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device select levels compared with control byte bits 3..1 |
| busy | input | 1 | Write cycle in progress; suppresses acknowledges |
| rd_addr | output | 15 | Read port address (the address pointer) |
| rd_data | input | 8 | Byte at `rd_addr`, combinational |
| wr_strobe | output | 1 | One-cycle pulse per received write data byte |
| wr_addr | output | 15 | Address of the byte on `wr_data` |
| wr_data | output | 8 | Received write data byte |
| wr_commit | output | 1 | One-cycle pulse on Stop ending a write with data |

## Verification
A wrong bit counter or state shows at the ports within one byte time. An acknowledge then lands on the wrong clock, or a read byte comes out shifted, and the master-side model sees it at the next clock high phase. A wrong address pointer stays hidden until the next read or write strobe, and then shows as a wrong data value or a wrong `wr_addr`. For that reason every write is checked by address and every read is followed by a current-address read. Drive timing is compared on every system clock: each change of `sda_oe` is checked against the SCL level and the time since SCL last fell.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int AW        = 15,
  parameter int PAGE_BITS = 6,
  parameter int HOLD_CYC  = 60,
  parameter int FILT      = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [2:0]    strap,
  input  logic          busy,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int HI = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_IGNORE, S_CTRL, S_ADDRH, S_ADDRL, S_WDATA, S_RDATA} st_t;

  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_p, sda_p;
  st_t             st;
  logic [3:0]      bcnt;
  logic            seen_hi, rw, mack, pend, wrote;
  logic [7:0]      shreg, txsh;
  logic [HI-1:0]   addr_hi;
  logic [AW-1:0]   ptr;
  logic [HW-1:0]   hold_cnt;

  wire scl_rise = scl_f & ~scl_p;
  wire scl_fall = ~scl_f & scl_p;
  wire start_c  = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_c   = scl_f & scl_p & ~sda_p & sda_f;
  wire hit      = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap) && !busy;
  wire active   = (st != S_IDLE) && (st != S_IGNORE);
  wire recv_end = scl_fall && seen_hi && bcnt == 4'd7 && active && st != S_RDATA;

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; seen_hi <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      pend <= 1'b0; wrote <= 1'b0; shreg <= '0; txsh <= '0; addr_hi <= '0;
      ptr <= '0; hold_cnt <= '0; sda_oe <= 1'b0;
      wr_strobe <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      wr_commit <= 1'b0;
      if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (hold_cnt == HW'(1)) sda_oe <= pend;
      end
      if (start_c) begin
        st <= S_CTRL; bcnt <= '0; seen_hi <= 1'b0; wrote <= 1'b0;
        pend <= 1'b0; hold_cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        if (st == S_WDATA && wrote) wr_commit <= 1'b1;
        st <= S_IDLE; wrote <= 1'b0; pend <= 1'b0; hold_cnt <= '0; sda_oe <= 1'b0;
      end else if (active && scl_rise) begin
        seen_hi <= 1'b1;
        if (bcnt != 4'd8) shreg <= {shreg[6:0], sda_f};
        else mack <= ~sda_f;
      end else if (active && scl_fall && seen_hi) begin
        seen_hi  <= 1'b0;
        hold_cnt <= HW'(HOLD_CYC);
        if (bcnt == 4'd7) begin
          bcnt <= 4'd8;
          pend <= !busy;
          case (st)
            S_CTRL:  if (hit) rw <= shreg[0]; else begin st <= S_IGNORE; pend <= 1'b0; end
            S_ADDRH: if (busy) st <= S_IGNORE; else addr_hi <= shreg[HI-1:0];
            S_ADDRL: if (busy) st <= S_IGNORE; else ptr <= {addr_hi, shreg};
            S_WDATA: if (busy) st <= S_IGNORE;
                     else begin
                       wr_strobe <= 1'b1; wr_addr <= ptr; wr_data <= shreg; wrote <= 1'b1;
                       ptr <= {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
                     end
            default: pend <= 1'b0;
          endcase
        end else if (bcnt == 4'd8) begin
          bcnt <= '0;
          pend <= 1'b0;
          case (st)
            S_CTRL:  st <= rw ? S_RDATA : S_ADDRH;
            S_ADDRH: st <= S_ADDRL;
            S_ADDRL: st <= S_WDATA;
            default: ;
          endcase
          if ((st == S_CTRL && rw) || (st == S_RDATA && mack)) begin
            txsh <= rd_data;
            pend <= ~rd_data[7];
            ptr  <= ptr + 1'b1;
          end else if (st == S_RDATA) begin
            st <= S_IGNORE;
          end
        end else begin
          bcnt <= bcnt + 1'b1;
          if (st == S_RDATA) begin
            txsh <= {txsh[6:0], 1'b0};
            pend <= ~txsh[6];
          end
        end
      end
    end
  end

  assert_drive_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  assert_start_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_CTRL && bcnt == 4'd0 && !sda_oe));
  assert_stop_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe));
  assert_busy_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_end && busy) |=> (st == S_IGNORE && !wr_strobe));
  assert_commit_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !wr_strobe);
  assert_read_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDATA && $past(ptr) == {AW{1'b1}} && ptr != $past(ptr)) |-> ptr == '0);
endmodule

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
  localparam int HOLD = 60;
  localparam int HALF = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, wr_strobe, wr_commit;
  logic [14:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, commits = 0, low_cnt = 0;
  logic prev_oe = 1'b0;
  logic [22:0] wq[$];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction
  assign rd_data = mem(rd_addr);

  i2c_mem_slave #(.HOLD_CYC(HOLD)) u_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap(strap), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wr_strobe) wq.push_back({wr_addr, wr_data});
    if (wr_commit) commits++;
    if (rst_n && sda_oe != prev_oe)
      chk(!scl_m && low_cnt >= HOLD, "R11 drive change timing", low_cnt, HOLD);
    prev_oe = sda_oe;
    low_cnt = scl_m ? 0 : low_cnt + 1;
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic start_c();
    sda_m = 1; scl_m = 1; w(HALF); sda_m = 0; w(HALF); scl_m = 0;
  endtask
  task automatic rstart_c();
    w(HALF/2); sda_m = 1; w(HALF/2); scl_m = 1; w(HALF); sda_m = 0; w(HALF); scl_m = 0;
  endtask
  task automatic stop_c();
    w(HALF/2); sda_m = 0; w(HALF/2); scl_m = 1; w(HALF); sda_m = 1; w(HALF);
  endtask
  task automatic bit_c(input logic b, output logic s);
    w(HALF/2); sda_m = b; w(HALF/2); scl_m = 1; w(HALF/2); s = sda_line; w(HALF/2); scl_m = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) bit_c(b[i], s);
    bit_c(1'b1, s);
    chk(!s == exp_ack, tag, !s, exp_ack);
  endtask

  task automatic recv(input logic [7:0] exp, input bit m_ack, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin bit_c(1'b1, s); got[i] = s; end
    bit_c(!m_ack, s);
    chk(got == exp, tag, got, exp);
  endtask

  task automatic wchk(input logic [14:0] a, input logic [7:0] d, input string tag);
    logic [22:0] e;
    if (wq.size() == 0) begin chk(0, tag, 0, {a, d}); return; end
    e = wq.pop_front();
    chk(e == {a, d}, tag, e, {a, d});
  endtask

  initial begin
    w(5); rst_n = 1; w(3);
    chk(sda_oe == 0 && wr_strobe == 0 && wr_commit == 0, "R12 reset outputs",
        {sda_oe, wr_strobe, wr_commit}, 0);
    w(20);
    // write with page wrap
    start_c();
    send(8'hAA, 1, "R1 write control ack");
    send(8'hF2, 1, "R3 address high ack");
    send(8'h3E, 1, "R3 address low ack");
    send(8'h11, 1, "R3 data ack");
    send(8'h22, 1, "R3 data ack");
    send(8'h33, 1, "R4 data ack at page end");
    stop_c(); w(20);
    wchk(15'h723E, 8'h11, "R3 first byte, bit 7 of high byte ignored");
    wchk(15'h723F, 8'h22, "R3 second byte");
    wchk(15'h7200, 8'h33, "R4 page wrap");
    chk(commits == 1, "R5 commit after stop", commits, 1);
    // busy polling
    busy = 1;
    start_c(); send(8'hAA, 0, "R10 no ack while busy"); send(8'h00, 0, "R10 ignored after nack"); stop_c();
    busy = 0;
    start_c(); send(8'hAA, 1, "R10 ack once idle"); stop_c();
    // wrong strap and wrong code
    start_c(); send(8'hA2, 0, "R2 wrong strap"); send(8'h00, 0, "R2 later byte ignored");
    send(8'h5A, 0, "R2 later byte ignored"); stop_c();
    start_c(); send(8'hBA, 0, "R2 wrong code"); stop_c(); w(20);
    chk(wq.size() == 0, "R2 no write strobe", wq.size(), 0);
    // random read, then release after nack
    start_c(); send(8'hAA, 1, "R6 control"); send(8'h01, 1, "R6 addr hi"); send(8'h05, 1, "R6 addr lo");
    rstart_c(); send(8'hAB, 1, "R1 read control ack");
    recv(mem(15'h0105), 0, "R6 random read data");
    recv(8'hFF, 0, "R8 released after master nack");
    stop_c();
    chk(commits == 1, "R5 no commit without data", commits, 1);
    start_c(); send(8'hAB, 1, "R9 control"); recv(mem(15'h0106), 0, "R9 current address read"); stop_c();
    // sequential read across the top
    start_c(); send(8'hAA, 1, "R7 control"); send(8'h7F, 1, "R7 addr hi"); send(8'hFE, 1, "R7 addr lo");
    rstart_c(); send(8'hAB, 1, "R7 read control");
    recv(mem(15'h7FFE), 1, "R7 seq byte 0");
    recv(mem(15'h7FFF), 1, "R7 seq byte 1");
    recv(mem(15'h0000), 0, "R7 wrap to zero");
    stop_c();
    start_c(); send(8'hAB, 1, "R9 control"); recv(mem(15'h0001), 0, "R9 after wrap"); stop_c();
    // abort by repeated start mid address
    start_c(); send(8'hAA, 1, "R13 control"); send(8'h00, 1, "R13 addr hi");
    rstart_c(); send(8'hAB, 1, "R13 restart control");
    recv(mem(15'h0002), 0, "R13 pointer untouched by partial address"); stop_c();
    // write ended by repeated start: no commit
    start_c(); send(8'hAA, 1, "R5 control"); send(8'h00, 1, "R5 addr hi"); send(8'h10, 1, "R5 addr lo");
    send(8'h55, 1, "R5 data"); rstart_c(); stop_c(); w(20);
    wchk(15'h0010, 8'h55, "R3 single byte write");
    chk(commits == 1, "R5 no commit on restart", commits, 1);
    start_c(); send(8'hAB, 1, "R9 control"); recv(mem(15'h0011), 0, "R9 after write"); stop_c();
    w(50);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule